// File: doc/BRIEF.md
# Two-level prioritized interrupt vectoring controller

This block sits next to a small CPU sequencer and decides when that sequencer is diverted into an interrupt service routine. On every clock it evaluates the pending flags of all sources, masked by per-source enables and a global enable, and splits them into a high and a low priority level using one priority bit per source. When the CPU signals the final clock of its current instruction and a source is eligible, the controller picks a winner, pulses a one-hot acknowledge to it, and raises a call request. It then holds the CPU for a fixed hardware call sequence while presenting the winner's vector address.

Two in-service bits form a two-deep nesting record. A low-level routine can be preempted by a high-level request. A request is held off while a routine at its own or a higher level is still marked in service. Only the dedicated return-from-interrupt strobe clears a marker, and it always clears the most recently entered level. A routine that leaves through any other path keeps its level blocked. With the default four-cycle call, the shortest path from a flag rising to the first routine fetch is five clocks.

Top module: `irq_vector_ctrl`

## Requirements
- R1: During reset and in the first cycle after it, `call_req_o`, `ack_o`, `vec_addr_o`, `cpu_hold_o` and `in_svc_o` are all zero.
- R2: After a decision edge, `cpu_hold_o` is high for exactly CALL_CYCLES (default 4) consecutive cycles. No new decision is taken at any edge where the hold counter is non-zero, so a new call never starts in the cycle right after a hold cycle.
- R3: `call_req_o` is high only in the first hold cycle. With every condition met, a flag raised before an edge gives the pattern: call request in the next cycle, hold low again 5 cycles after the flag was applied (1 detect plus 4 call).
- R4: A low-level request (priority bit 0) is eligible only when `in_svc_o` is 2'b00. A high-level request (priority bit 1) is eligible only when `in_svc_o[1]` is 0.
- R5: A high-level request is taken while a low-level routine is in service, and `in_svc_o` becomes 2'b11.
- R6: A decision is taken only at a clock edge where `instr_last_i` is high. A pending request waits while it is low.
- R7: On an edge with `reti_i` high, `in_svc_o[1]` is cleared if set, otherwise `in_svc_o[0]` is cleared. No other event clears a bit. The decision at that same edge still sees the markers as they were before the clear.
- R8: `ack_o` is one-hot for one cycle, coincident with `call_req_o`. Any eligible high-level source beats every low-level source, and within a level the lowest index wins.
- R9: While `cpu_hold_o` is high, `vec_addr_o` equals VEC_BASE (default 16'h0003) plus the winner index times 8, and it is stable. It is zero otherwise.
- R10: While `gie_i` is low, no decision is taken, but `reti_i` still clears in-service markers.
- R11: A source whose `en_i` bit is 0 never wins, even when it is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pend_i | input | NUM_SRC | Pending flag per source |
| en_i | input | NUM_SRC | Enable per source |
| prio_i | input | NUM_SRC | Priority level per source (1 = high) |
| gie_i | input | 1 | Global interrupt enable |
| instr_last_i | input | 1 | Current clock is the final one of the executing instruction |
| reti_i | input | 1 | Return-from-interrupt completed this clock |
| call_req_o | output | 1 | Hardware call requested (first call cycle) |
| ack_o | output | NUM_SRC | One-cycle one-hot acknowledge to the winner |
| vec_addr_o | output | ADDR_W | Vector address of the winner during the call |
| cpu_hold_o | output | 1 | CPU held for the call sequence |
| in_svc_o | output | 2 | In-service markers: bit 1 high level, bit 0 low level |

## Verification
The hardest states to reach are those where a return strobe, a preempting high-level request and a still-pending low-level request all meet. This covers the clearing of the high marker only, and a decision at the very edge of a return that must still see the old markers. Directed sequences first build the nested 2'b11 state and then return one level at a time, with a blocked low request held pending. A long random phase follows that fires return strobes only while a marker is set, toggles the instruction-boundary and global-enable inputs, and reshuffles priorities. A behavioural reference model in the bench is compared on every clock.

// File: rtl/irqv_pkg.sv
package irqv_pkg;

   localparam int unsigned IRQV_MAX_SRC = 32;
   localparam int unsigned IRQV_LEVELS  = 2;

   // index of the lowest set bit, 0 when none is set
   function automatic int unsigned irqv_lowest(input logic [IRQV_MAX_SRC-1:0] v);
      int unsigned r;
      r = 0;
      for (int i = IRQV_MAX_SRC - 1; i >= 0; i--) begin
         if (v[i]) r = i;
      end
      return r;
   endfunction

endpackage

// File: rtl/irqv_arbiter.sv
module irqv_arbiter
   import irqv_pkg::*;
#(
   parameter int unsigned NUM_SRC = 8,
   parameter int unsigned IDX_W   = 3
) (
   input  logic [NUM_SRC-1:0] pend_i,
   input  logic [NUM_SRC-1:0] en_i,
   input  logic [NUM_SRC-1:0] prio_i,
   input  logic [1:0]         svc_i,
   input  logic               allow_i,
   output logic               grant_o,
   output logic               grant_hi_o,
   output logic [IDX_W-1:0]   grant_idx_o
);

   logic [IRQV_LEVELS-1:0] lvl_hit;
   logic [IDX_W-1:0]       lvl_idx [IRQV_LEVELS];

   for (genvar lv = 0; lv < IRQV_LEVELS; lv++) begin : g_lvl
      logic               elig;
      logic [NUM_SRC-1:0] req;
      if (lv == 1) begin : g_hi
         assign elig = ~svc_i[1];
         assign req  = pend_i & en_i & prio_i;
      end else begin : g_lo
         assign elig = (svc_i == 2'b00);
         assign req  = pend_i & en_i & ~prio_i;
      end
      assign lvl_hit[lv] = elig & (|req);
      assign lvl_idx[lv] = IDX_W'(irqv_lowest(IRQV_MAX_SRC'(req)));
   end

   assign grant_hi_o  = lvl_hit[1];
   assign grant_o     = allow_i & (|lvl_hit);
   assign grant_idx_o = lvl_hit[1] ? lvl_idx[1] : lvl_idx[0];

endmodule

// File: rtl/irqv_call_seq.sv
module irqv_call_seq #(
   parameter int unsigned CALL_CYCLES = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   output logic busy_o,
   output logic first_o
);

   localparam int unsigned CNT_W = $clog2(CALL_CYCLES + 1);

   logic [CNT_W-1:0] cnt_q;
   logic             first_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         first_q <= 1'b0;
      end else if (start_i) begin
         cnt_q   <= CNT_W'(CALL_CYCLES);
         first_q <= 1'b1;
      end else begin
         first_q <= 1'b0;
         if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
      end
   end

   assign busy_o  = (cnt_q != '0);
   assign first_o = first_q;

endmodule

// File: rtl/irqv_svc_stack.sv
module irqv_svc_stack (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       set_i,
   input  logic       set_hi_i,
   input  logic       ret_i,
   output logic [1:0] svc_o
);

   logic [1:0] svc_q, svc_d;

   always_comb begin
      svc_d = svc_q;
      if (ret_i) begin
         if (svc_q[1]) svc_d[1] = 1'b0;
         else          svc_d[0] = 1'b0;
      end
      if (set_i) begin
         if (set_hi_i) svc_d[1] = 1'b1;
         else          svc_d[0] = 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) svc_q <= 2'b00;
      else        svc_q <= svc_d;
   end

   assign svc_o = svc_q;

endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
   import irqv_pkg::*;
#(
   parameter int unsigned NUM_SRC         = 8,
   parameter int unsigned ADDR_W          = 16,
   parameter logic [31:0] VEC_BASE        = 32'h0003,
   parameter int unsigned VEC_STRIDE_LOG2 = 3,
   parameter int unsigned CALL_CYCLES     = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] pend_i,
   input  logic [NUM_SRC-1:0] en_i,
   input  logic [NUM_SRC-1:0] prio_i,
   input  logic               gie_i,
   input  logic               instr_last_i,
   input  logic               reti_i,
   output logic               call_req_o,
   output logic [NUM_SRC-1:0] ack_o,
   output logic [ADDR_W-1:0]  vec_addr_o,
   output logic               cpu_hold_o,
   output logic [1:0]         in_svc_o
);

   localparam int unsigned IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

   if (NUM_SRC < 1 || NUM_SRC > IRQV_MAX_SRC) begin : g_bad_src
      $error("irq_vector_ctrl: NUM_SRC out of range");
   end
   if (CALL_CYCLES < 1) begin : g_bad_call
      $error("irq_vector_ctrl: CALL_CYCLES must be at least 1");
   end
   if (ADDR_W < IDX_W + VEC_STRIDE_LOG2) begin : g_bad_addr
      $error("irq_vector_ctrl: ADDR_W too narrow for the vector table");
   end

   logic             busy, first, allow;
   logic             grant, grant_hi;
   logic [IDX_W-1:0] grant_idx;
   logic [IDX_W-1:0] idx_q;
   logic [NUM_SRC-1:0] ack_q;
   logic [1:0]       svc;

   assign allow = gie_i & instr_last_i & ~busy;

   irqv_arbiter #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_arb (
      .pend_i      (pend_i),
      .en_i        (en_i),
      .prio_i      (prio_i),
      .svc_i       (svc),
      .allow_i     (allow),
      .grant_o     (grant),
      .grant_hi_o  (grant_hi),
      .grant_idx_o (grant_idx)
   );

   irqv_call_seq #(.CALL_CYCLES(CALL_CYCLES)) u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (grant),
      .busy_o  (busy),
      .first_o (first)
   );

   irqv_svc_stack u_svc (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_i    (grant),
      .set_hi_i (grant_hi),
      .ret_i    (reti_i),
      .svc_o    (svc)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         idx_q <= '0;
         ack_q <= '0;
      end else begin
         ack_q <= '0;
         if (grant) begin
            idx_q <= grant_idx;
            ack_q <= NUM_SRC'(1) << grant_idx;
         end
      end
   end

   assign call_req_o = first;
   assign ack_o      = ack_q;
   assign cpu_hold_o = busy;
   assign in_svc_o   = svc;
   assign vec_addr_o = busy ? (ADDR_W'(VEC_BASE) + (ADDR_W'(idx_q) << VEC_STRIDE_LOG2))
                            : '0;

endmodule

// File: rtl/irqv_checker.sv
module irqv_checker #(
   parameter int unsigned NUM_SRC = 8,
   parameter int unsigned ADDR_W  = 16
) (
   input logic               clk,
   input logic               rst_n,
   input logic               gie_i,
   input logic               instr_last_i,
   input logic               reti_i,
   input logic               call_req_o,
   input logic [NUM_SRC-1:0] ack_o,
   input logic [ADDR_W-1:0]  vec_addr_o,
   input logic               cpu_hold_o,
   input logic [1:0]         in_svc_o
);

   assert_call_in_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      call_req_o |-> cpu_hold_o);

   assert_no_start_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
      call_req_o |-> !$past(cpu_hold_o));

   assert_hold_starts_call_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_hold_o && !$past(cpu_hold_o)) |-> call_req_o);

   assert_ack_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(ack_o) && ((ack_o != '0) == call_req_o));

   assert_boundary_R6: assert property (@(posedge clk) disable iff (!rst_n)
      call_req_o |-> $past(instr_last_i));

   assert_gie_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
      call_req_o |-> $past(gie_i));

   assert_hi_blocks_R4: assert property (@(posedge clk) disable iff (!rst_n)
      call_req_o |-> !$past(in_svc_o[1]));

   assert_hi_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(in_svc_o[1]) |-> $past(reti_i));

   assert_lo_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(in_svc_o[0]) |-> ($past(reti_i) && !$past(in_svc_o[1])));

   assert_vec_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_hold_o && !call_req_o) |-> $stable(vec_addr_o));

   assert_vec_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !cpu_hold_o |-> (vec_addr_o == '0));

endmodule

bind irq_vector_ctrl irqv_checker #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_irqv_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .gie_i        (gie_i),
   .instr_last_i (instr_last_i),
   .reti_i       (reti_i),
   .call_req_o   (call_req_o),
   .ack_o        (ack_o),
   .vec_addr_o   (vec_addr_o),
   .cpu_hold_o   (cpu_hold_o),
   .in_svc_o     (in_svc_o)
);

// File: tb/irq_vector_ctrl_tb_top.sv
`timescale 1ns/1ps
module irq_vector_ctrl_tb_top;

   localparam int N     = 8;
   localparam int AW    = 16;
   localparam int BASE  = 3;
   localparam int NCALL = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [N-1:0]  pend = '0, en = '1, prio = '0;
   logic          gie = 1'b0, ilast = 1'b0, reti = 1'b0;
   logic          call_req_o, cpu_hold_o;
   logic [N-1:0]  ack_o;
   logic [AW-1:0] vec_addr_o;
   logic [1:0]    in_svc_o;

   always #2.5 clk = ~clk;

   irq_vector_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .pend_i(pend), .en_i(en), .prio_i(prio),
      .gie_i(gie), .instr_last_i(ilast), .reti_i(reti),
      .call_req_o(call_req_o), .ack_o(ack_o), .vec_addr_o(vec_addr_o),
      .cpu_hold_o(cpu_hold_o), .in_svc_o(in_svc_o)
   );

   int n_chk = 0, n_fail = 0;
   bit done = 0;

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   int m_cnt = 0, m_idx = 0;
   bit m_first = 0;
   bit m_svc_hi = 0, m_svc_lo = 0;

   always @(posedge clk) begin
      int win;
      bit win_hi, nhi, nlo;
      if (!rst_n) begin
         m_cnt = 0; m_idx = 0; m_first = 0; m_svc_hi = 0; m_svc_lo = 0;
      end else begin
         win = -1; win_hi = 0;
         if (m_cnt == 0 && gie && ilast) begin
            if (!m_svc_hi)
               for (int i = N - 1; i >= 0; i--)
                  if (pend[i] && en[i] && prio[i]) begin win = i; win_hi = 1; end
            if (win < 0 && !m_svc_hi && !m_svc_lo)
               for (int i = N - 1; i >= 0; i--)
                  if (pend[i] && en[i] && !prio[i]) win = i;
         end
         nhi = m_svc_hi; nlo = m_svc_lo;
         if (reti) begin
            if (m_svc_hi) nhi = 0; else nlo = 0;
         end
         if (win >= 0) begin
            if (win_hi) nhi = 1; else nlo = 1;
            m_cnt = NCALL; m_first = 1; m_idx = win;
         end else begin
            m_first = 0;
            if (m_cnt > 0) m_cnt--;
         end
         m_svc_hi = nhi; m_svc_lo = nlo;
      end
   end

   always @(negedge clk) begin
      int e_vec;
      if (rst_n && !done) begin
         e_vec = (m_cnt > 0) ? BASE + m_idx * 8 : 0;
         chk(cpu_hold_o == (m_cnt > 0), "R2 hold", cpu_hold_o, m_cnt > 0);
         chk(call_req_o == m_first, "R3 call_req", call_req_o, m_first);
         chk(ack_o == (m_first ? N'(1) << m_idx : N'(0)), "R8 ack", ack_o,
             m_first ? (1 << m_idx) : 0);
         chk(vec_addr_o == AW'(e_vec), "R9 vector", vec_addr_o, e_vec);
         chk(in_svc_o == {m_svc_hi, m_svc_lo}, "R7 in-service", in_svc_o,
             {m_svc_hi, m_svc_lo});
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic tick();
      @(negedge clk);
   endtask

   task automatic finish_call();
      int guard = 0;
      while (cpu_hold_o && guard < 20) begin tick(); guard++; end
   endtask

   task automatic ret_pulse();
      reti = 1'b1; tick(); reti = 1'b0;
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1;
         n_fail++;
         $display("FAIL watchdog expired");
         summary();
         $finish;
      end
   end

   initial begin
      int lat;
      tick(); tick();
      chk(call_req_o == 0 && ack_o == 0 && vec_addr_o == 0 && cpu_hold_o == 0 && in_svc_o == 0,
          "R1 during reset", {call_req_o, ack_o, cpu_hold_o, in_svc_o}, 0);
      rst_n = 1'b1;
      tick();
      chk(cpu_hold_o == 0 && in_svc_o == 0, "R1 after reset", {cpu_hold_o, in_svc_o}, 0);

      // latency and vector address
      gie = 1; ilast = 1; pend = 8'h04;
      tick();
      chk(call_req_o == 1, "R3 call after one edge", call_req_o, 1);
      chk(vec_addr_o == AW'(BASE + 16), "R9 vector of source 2", vec_addr_o, BASE + 16);
      pend = '0;
      lat = 1;
      while (cpu_hold_o && lat < 20) begin tick(); lat++; end
      chk(lat == 5, "R3 flag to routine fetch", lat, 5);
      chk(in_svc_o == 2'b01, "R7 low marker set", in_svc_o, 1);

      // low request blocked by low in service
      pend[5] = 1;
      repeat (3) begin tick(); chk(call_req_o == 0, "R4 low blocked", call_req_o, 0); end

      // high preempts low
      prio[6] = 1; pend[6] = 1;
      tick();
      chk(ack_o == 8'h40, "R5 high preempts", ack_o, 8'h40);
      pend[6] = 0;
      finish_call();
      chk(in_svc_o == 2'b11, "R5 nested markers", in_svc_o, 3);

      // returns, one level at a time
      ret_pulse();
      chk(in_svc_o == 2'b01 && call_req_o == 0, "R7 high cleared first", in_svc_o, 1);
      ret_pulse();
      chk(in_svc_o == 2'b00 && call_req_o == 0, "R7 decision sees old markers", in_svc_o, 0);
      tick();
      chk(ack_o == 8'h20, "R7 blocked low taken after return", ack_o, 8'h20);
      pend = '0; prio = '0;
      finish_call(); ret_pulse();

      // tie inside a level
      pend = 8'h8A;
      tick();
      chk(ack_o == 8'h02, "R8 lowest index wins", ack_o, 8'h02);
      pend = '0;
      finish_call(); ret_pulse();

      // instruction boundary
      ilast = 0; pend[4] = 1;
      repeat (3) begin tick(); chk(call_req_o == 0, "R6 waits for boundary", call_req_o, 0); end
      ilast = 1;
      tick();
      chk(ack_o == 8'h10, "R6 taken at boundary", ack_o, 8'h10);
      pend = '0;
      finish_call();

      // global enable low
      gie = 0; prio[0] = 1; pend[0] = 1;
      repeat (3) begin tick(); chk(call_req_o == 0, "R10 no start when disabled", call_req_o, 0); end
      ret_pulse();
      chk(in_svc_o == 2'b00, "R10 return still clears", in_svc_o, 0);
      gie = 1;
      tick();
      chk(ack_o == 8'h01, "R10 start after enable", ack_o, 8'h01);
      pend = '0;
      finish_call(); ret_pulse(); prio = '0;

      // per-source enable
      en = 8'hF7; pend[3] = 1;
      repeat (3) begin tick(); chk(call_req_o == 0, "R11 disabled source ignored", call_req_o, 0); end
      chk(in_svc_o == 2'b00, "R11 markers untouched", in_svc_o, 0);
      en = '1;
      tick();
      chk(ack_o == 8'h08, "R11 taken once enabled", ack_o, 8'h08);
      pend = '0;
      finish_call(); ret_pulse();

      // random phase, model compared every clock
      for (int c = 0; c < 6000; c++) begin
         if (c % 500 == 0) prio = N'($urandom);
         pend  = (pend & ~ack_o) | (($urandom % 6 == 0) ? N'(1) << ($urandom % N) : N'(0));
         en    = ($urandom % 20 == 0) ? N'($urandom) : en | N'($urandom);
         gie   = ($urandom % 10) != 0;
         ilast = ($urandom % 10) < 7;
         reti  = (m_svc_hi || m_svc_lo) && ($urandom % 9 == 0);
         tick();
      end
      reti = 0; pend = '0;
      tick(); tick();

      done = 1;
      summary();
      $finish;
   end

endmodule